// File: doc/BRIEF.md
# Ping-Pong Receive Packet Buffer

This block sits between a host-side packet engine and a CPU and holds incoming IN-packet payload in two alternating packet banks. The engine pushes bytes one per strobe into the bank being filled. It then either commits the packet, making it visible to the CPU, or discards it after a CRC or data-toggle problem, which throws away the partial fill.

The CPU sees only the oldest committed packet. It reads the byte count, then pops that many bytes through a single data output. It hands the bank back by pulsing a write-one-to-clear strobe on the data-available flag. If the second bank already holds a committed packet at that moment, the flag stays asserted without a gap, and the count and data move over to that packet. While both banks hold committed packets the engine is told the buffer is full. The bank size is a parameter (64 bytes by default).

Top module: `rx_pingpong_fifo`

## Requirements
- R1: After reset `avail_irq` and `full` are 0 and `byte_cnt` reads 0.
- R2: A commit after N byte strobes (N up to the bank size) sets `avail_irq` on the next clock edge, and `byte_cnt` then reads N.
- R3: With `avail_irq` high, `rd_data` shows the first byte of the packet, and each `rd_pop` advances it to the next byte in arrival order.
- R4: A pop while `rd_data` already shows the last byte of the packet leaves the read position and `rd_data` unchanged.
- R5: A discard drops the bytes written since the last commit or discard. `avail_irq` and `byte_cnt` stay unchanged, and the next committed packet contains none of the dropped bytes.
- R6: An `irq_clear` pulse while `avail_irq` is high releases the current bank. With no other committed packet, `avail_irq` reads 0 and `byte_cnt` reads 0 on the next cycle.
- R7: If the other bank holds a committed packet when `irq_clear` is pulsed, `avail_irq` remains 1 on the next cycle. `byte_cnt` and `rd_data` then switch to that packet, starting from its first byte.
- R8: `full` is 1 while both banks hold committed packets. Byte strobes and commits made while `full` is 1 are ignored.
- R9: Byte strobes beyond the bank size within one packet are dropped, and the committed count saturates at the bank size.
- R10: `rd_pop` and `irq_clear` have no effect while `avail_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W | Received byte from the packet engine |
| wr_en | input | 1 | Byte strobe, stores `wr_data` into the filling bank |
| commit | input | 1 | Ends the filling packet as valid |
| discard | input | 1 | Ends the filling packet as bad and rewinds its fill |
| full | output | 1 | Both banks hold committed packets |
| rd_pop | input | 1 | CPU data-register read, advances the read position |
| irq_clear | input | 1 | CPU write-one to the data-available flag |
| rd_data | output | DATA_W | Byte at the read position of the current packet |
| byte_cnt | output | $clog2(BUF_BYTES+1) | Byte count of the current packet, 0 when none |
| avail_irq | output | 1 | Data-available interrupt flag |

## Verification
The embedded properties assume the engine never raises `commit` and `discard` together with `wr_en`, and that it waits for `full` to drop before starting another packet. The bench honours this by ending every packet on a separate cycle after its last byte strobe. The only writes made during `full` are a deliberate probe of R8. CPU-side strobes are single-cycle pulses on negative edges, and they include pops and clears issued with nothing available.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // two alternating packet banks
  localparam int NUM_BANKS = 2;
  typedef logic bank_sel_t;
endpackage

// File: rtl/rx_pkt_buf.sv
module rx_pkt_buf #(
  parameter int BUF_BYTES = 64,
  parameter int DATA_W    = 8,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int PTR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_en,
  input  logic              discard_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  pkt_cnt
);

  logic [DATA_W-1:0] mem [BUF_BYTES];
  logic [CNT_W-1:0]  wptr_q, wptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              room;
  logic              store;

  assign room  = (wptr_q < CNT_W'(BUF_BYTES));
  assign store = wr_en && room && !commit_en && !discard_en;

  always_comb begin
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (commit_en) begin
      cnt_d  = wptr_q;
      wptr_d = '0;
    end else if (discard_en) begin
      wptr_d = '0;
    end else if (store) begin
      wptr_d = wptr_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage array without reset
  always_ff @(posedge clk) begin
    if (store) begin
      mem[wptr_q[PTR_W-1:0]] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
  assign pkt_cnt = cnt_q;

  a_r9_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q <= CNT_W'(BUF_BYTES));

  a_r5_discard_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_en && !commit_en) |=> (wptr_q == '0));

  a_r9_full_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !room && !commit_en && !discard_en) |=> $stable(wptr_q));

endmodule

// File: rtl/rx_bank_ctrl.sv
module rx_bank_ctrl
  import rxq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int PTR_W    = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             irq_clear,
  input  logic             rd_pop,
  input  logic [CNT_W-1:0] cnt_sel,
  output bank_sel_t        fill_sel,
  output bank_sel_t        read_sel,
  output logic [PTR_W-1:0] rptr,
  output logic             full,
  output logic             avail
);

  logic [NUM_BANKS-1:0] valid_q, valid_d;
  bank_sel_t            fill_q, fill_d;
  bank_sel_t            read_q, read_d;
  logic [PTR_W-1:0]     rptr_q, rptr_d;
  logic                 commit_ok, clear_ok, pop_ok;

  assign commit_ok = commit && !valid_q[fill_q];
  assign clear_ok  = irq_clear && valid_q[read_q];
  assign pop_ok    = rd_pop && valid_q[read_q] && !clear_ok &&
                     ((CNT_W'(rptr_q) + CNT_W'(1)) < cnt_sel);

  always_comb begin
    valid_d = valid_q;
    fill_d  = fill_q;
    read_d  = read_q;
    rptr_d  = rptr_q;
    if (commit_ok) begin
      valid_d[fill_q] = 1'b1;
      fill_d          = ~fill_q;
    end
    if (clear_ok) begin
      valid_d[read_q] = 1'b0;
      read_d          = ~read_q;
      rptr_d          = '0;
    end else if (pop_ok) begin
      rptr_d = rptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      fill_q  <= 1'b0;
      read_q  <= 1'b0;
      rptr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      fill_q  <= fill_d;
      read_q  <= read_d;
      rptr_q  <= rptr_d;
    end
  end

  assign fill_sel = fill_q;
  assign read_sel = read_q;
  assign rptr     = rptr_q;
  assign full     = valid_q[fill_q];
  assign avail    = valid_q[read_q];

  a_r8_full_means_both: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (valid_q == 2'b11));

  a_r4_rptr_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> ((rptr_q == '0) || (CNT_W'(rptr_q) < cnt_sel)));

  a_r6_clear_swaps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && avail) |=> (read_q != $past(read_q)) && (rptr_q == '0));

  a_r7_reassert_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && (valid_q == 2'b11)) |=> avail);

  a_r2_commit_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !full) |=> avail);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && !commit) |=> $stable(read_q) && $stable(rptr_q));

endmodule

// File: rtl/rx_pingpong_fifo.sv
module rx_pingpong_fifo
  import rxq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int DATA_W    = 8,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int PTR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              commit,
  input  logic              discard,
  output logic              full,
  input  logic              rd_pop,
  input  logic              irq_clear,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              avail_irq
);

  bank_sel_t         fill_sel, read_sel;
  logic [PTR_W-1:0]  rptr;
  logic              full_w, avail_w;
  logic [DATA_W-1:0] bank_rd  [NUM_BANKS];
  logic [CNT_W-1:0]  bank_cnt [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (fill_sel == 1'(b));

    rx_pkt_buf #(
      .BUF_BYTES (BUF_BYTES),
      .DATA_W    (DATA_W)
    ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en && !full_w && hit),
      .wr_data    (wr_data),
      .commit_en  (commit && !full_w && hit),
      .discard_en (discard && !commit && !full_w && hit),
      .rd_addr    (rptr),
      .rd_data    (bank_rd[b]),
      .pkt_cnt    (bank_cnt[b])
    );
  end

  rx_bank_ctrl #(
    .BUF_BYTES (BUF_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .irq_clear (irq_clear),
    .rd_pop    (rd_pop),
    .cnt_sel   (bank_cnt[read_sel]),
    .fill_sel  (fill_sel),
    .read_sel  (read_sel),
    .rptr      (rptr),
    .full      (full_w),
    .avail     (avail_w)
  );

  assign full      = full_w;
  assign avail_irq = avail_w;
  assign rd_data   = bank_rd[read_sel];
  assign byte_cnt  = avail_w ? bank_cnt[read_sel] : '0;

  a_r1_count_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_irq |-> (byte_cnt == '0));

endmodule

// File: tb/test_rx_pingpong_fifo.sv
`timescale 1ns/1ps
module test_rx_pingpong_fifo;
  localparam int BUF_BYTES = 64;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DATA_W-1:0] wr_data;
  logic              wr_en, commit, discard, rd_pop, irq_clear;
  logic              full, avail_irq;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  byte_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rx_pingpong_fifo #(.BUF_BYTES(BUF_BYTES), .DATA_W(DATA_W)) i_rx_pingpong_fifo (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
    .commit(commit), .discard(discard), .full(full), .rd_pop(rd_pop),
    .irq_clear(irq_clear), .rd_data(rd_data), .byte_cnt(byte_cnt),
    .avail_irq(avail_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bytes base+i, then commit (end_ok=1) or discard
  task automatic send_pkt(input logic [7:0] base, input int len, input bit end_ok);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = base + 8'(i);
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (end_ok) commit = 1'b1; else discard = 1'b1;
    @(negedge clk);
    commit  = 1'b0;
    discard = 1'b0;
  endtask

  task automatic pop_once();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic clear_once();
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
  endtask

  task automatic read_pkt(input string req, input logic [7:0] base, input int len);
    chk({req, " count"}, 32'(byte_cnt), 32'(len));
    for (int i = 0; i < len; i++) begin
      chk({req, " data"}, 32'(rd_data), 32'(8'(base + 8'(i))));
      pop_once();
    end
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(avail_irq), 0);
    chk("R1 full", 32'(full), 0);
    chk("R1 count", 32'(byte_cnt), 0);
  endtask

  task automatic t_single();
    send_pkt(8'h10, 5, 1'b1);
    chk("R2 irq", 32'(avail_irq), 1);
    read_pkt("R3", 8'h10, 5);
    chk("R4 last byte held", 32'(rd_data), 32'h14);
    pop_once();
    pop_once();
    chk("R4 past count", 32'(rd_data), 32'h14);
    clear_once();
    chk("R6 irq released", 32'(avail_irq), 0);
    chk("R6 count zero", 32'(byte_cnt), 0);
  endtask

  task automatic t_discard();
    send_pkt(8'h50, 4, 1'b0);
    chk("R5 irq untouched", 32'(avail_irq), 0);
    chk("R5 count untouched", 32'(byte_cnt), 0);
    send_pkt(8'h60, 2, 1'b1);
    read_pkt("R5", 8'h60, 2);
    clear_once();
    chk("R5 release", 32'(avail_irq), 0);
  endtask

  task automatic t_double();
    send_pkt(8'h70, 3, 1'b1);
    chk("R8 not full one pkt", 32'(full), 0);
    send_pkt(8'h80, 6, 1'b1);
    chk("R8 full", 32'(full), 1);
    send_pkt(8'h90, 2, 1'b1);
    chk("R8 count kept", 32'(byte_cnt), 3);
    read_pkt("R3 first bank", 8'h70, 3);
    clear_once();
    chk("R7 irq stays", 32'(avail_irq), 1);
    chk("R8 full drops", 32'(full), 0);
    read_pkt("R7", 8'h80, 6);
    clear_once();
    chk("R8 ignored commit", 32'(avail_irq), 0);
  endtask

  task automatic t_overflow();
    send_pkt(8'h00, BUF_BYTES + 3, 1'b1);
    chk("R9 irq", 32'(avail_irq), 1);
    read_pkt("R9", 8'h00, BUF_BYTES);
    chk("R9 last kept", 32'(rd_data), 32'(BUF_BYTES - 1));
    clear_once();
  endtask

  task automatic t_idle();
    pop_once();
    clear_once();
    chk("R10 irq low", 32'(avail_irq), 0);
    send_pkt(8'hA0, 2, 1'b1);
    chk("R10 first byte", 32'(rd_data), 32'hA0);
    chk("R10 count", 32'(byte_cnt), 2);
    clear_once();
    pop_once();
    clear_once();
    send_pkt(8'hB0, 3, 1'b1);
    read_pkt("R10 later pkt", 8'hB0, 3);
    clear_once();
    chk("R10 final release", 32'(avail_irq), 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; commit = 1'b0;
    discard = 1'b0; rd_pop = 1'b0; irq_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_discard();
    t_double();
    t_overflow();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule